// File: doc/BRIEF.md
# Interrupt Endpoint Buffer Controller

This block holds the control register and handshake logic for one low-speed interrupt endpoint. The endpoint owns two 8-byte buffer banks. Firmware programs an 8-bit control word that holds these fields: enable, bank swap, a "host data arrived" flag, a "transmit buffer not ready" flag and a byte count. The packet engine presents decoded IN and OUT token strobes. One cycle later the block answers with the handshake to use. It also reports the buffer bank that serves the transaction and the number of bytes to send.

When the packet engine signals that a transaction has finished, the block updates the ready flags. It changes them only when the transaction succeeded and the block had granted it. Both flags work the opposite way to a "busy" bit. Hardware sets them, and firmware clears them to hand the buffer back.

The block also turns a byte index into an address in the shared 32-byte buffer space. Each of four endpoints has an 8-byte window in that space. This endpoint is number 3.

Top module: `usb_intr_ep_ctrl`

## Requirements
- R1: After reset the control word reads 0x00, `hs_valid` is 0 and no transaction is pending.
- R2: A firmware write (`cfg_wr`=1) replaces all eight control bits at the next clock edge, and `cfg_rdata` returns them. The fields are bit 7 enable, bit 6 bank swap, bit 5 OUT-ready, bit 4 IN-not-ready and bits 3:0 byte count.
- R3: An enabled IN token with bit 4 = 0 produces, exactly one cycle later, a one-cycle `hs_valid` pulse with `hs_code` = 1 (DATA). In the same cycle `tx_len` = min(count, 8).
- R4: An enabled IN token with bit 4 = 1 produces `hs_code` = 3 (NAK) with `tx_len` = 0. If `stall_req` is 1 it produces `hs_code` = 4 (STALL) instead.
- R5: After a granted IN, a completion with `xfer_ok`=1 sets bit 4. A completion with `xfer_ok`=0 leaves bit 4 unchanged.
- R6: An enabled OUT token with bit 5 = 0 produces `hs_code` = 2 (ACK), and a successful completion then sets bit 5. An OUT token with bit 5 = 1 produces NAK, and any completion that follows leaves the control word unchanged.
- R7: Bank selection depends on bit 6. With bit 6 = 0, IN uses bank 0 and OUT uses bank 1. With bit 6 = 1, IN uses bank 1 and OUT uses bank 0. The chosen bank is reported on `hs_bank` together with the reply.
- R8: `ram_addr` = 8 × 3 + `byte_idx`, which is 0x18 to 0x1F.
- R9: While bit 7 = 0, tokens produce no `hs_valid` pulse and completions change no flag.
- R10: If a hardware flag update and a firmware write fall on the same clock edge, every other bit takes the written value, and the bit that hardware sets ends up at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Firmware write strobe for the control word |
| cfg_wdata | input | 8 | Value written to the control word |
| cfg_rdata | output | 8 | Current control word |
| stall_req | input | 1 | Stall flag from a separate register |
| tok_in | input | 1 | Decoded IN token strobe |
| tok_out | input | 1 | Decoded OUT token strobe |
| xfer_done | input | 1 | Transaction finished strobe |
| xfer_ok | input | 1 | Transaction succeeded (qualifies xfer_done) |
| hs_valid | output | 1 | Reply pulse |
| hs_code | output | 3 | Reply: 1 DATA, 2 ACK, 3 NAK, 4 STALL |
| hs_bank | output | 1 | Buffer bank for this transaction |
| tx_len | output | 4 | Bytes to send on DATA |
| byte_idx | input | 3 | Byte index inside the buffer |
| ram_addr | output | 5 | Shared buffer address |

## Verification
The bench targets three corner cases:
- **Count above the buffer size.** A write of count 15 must yield 8 bytes. A design that does not clamp the count would overrun into another endpoint's window.
- **OUT token while data is still unread.** It must be refused with NAK, and the completion that follows must not set any flag. A design that took the data would overwrite data firmware has not read yet.
- **Failed IN completion and disabled endpoint.** A failed IN completion must leave the transmit flag clear, so the data is offered again. A disabled endpoint must stay silent. A wrong design would drop the retry or answer tokens it should ignore.

Two more checks follow. One applies a firmware write and a hardware set on the same edge; a design where firmware wins loses the host's data notification. The other checks both settings of the swap bit, which catches an inverted bank mapping.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

  localparam int CNT_W = 4;
  localparam int REG_W = 8;

  localparam int EN_BIT   = 7;
  localparam int SEL_BIT  = 6;
  localparam int ORDY_BIT = 5;
  localparam int INRDY_BIT = 4;

  typedef enum logic [2:0] {
    HS_NONE  = 3'd0,
    HS_DATA  = 3'd1,
    HS_ACK   = 3'd2,
    HS_NAK   = 3'd3,
    HS_STALL = 3'd4
  } hs_e;

  // Bytes actually sent: firmware count limited to the buffer depth.
  function automatic logic [CNT_W-1:0] clamp_len(input logic [CNT_W-1:0] cnt,
                                                  input int unsigned depth);
    int unsigned c;
    c = cnt;
    return (c > depth) ? CNT_W'(depth) : cnt;
  endfunction

  // Bank serving IN follows the swap bit, OUT uses the other one.
  function automatic logic pick_bank(input logic swap, input logic is_in);
    return is_in ? swap : ~swap;
  endfunction

  // Shared buffer address of byte idx in endpoint ep's window.
  function automatic int unsigned win_addr(input int unsigned ep,
                                           input int unsigned depth,
                                           input int unsigned idx);
    return ep * depth + idx;
  endfunction

endpackage

// File: rtl/ep_ctrl_reg.sv
module ep_ctrl_reg
  import usb_ep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fw_wr,
  input  logic [REG_W-1:0] fw_wdata,
  input  logic             hw_set_in,
  input  logic             hw_set_out,
  output logic [REG_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      if (fw_wr) q <= fw_wdata;
      // Hardware sets come last so they win over a same-edge write.
      if (hw_set_in)  q[INRDY_BIT] <= 1'b1;
      if (hw_set_out) q[ORDY_BIT]  <= 1'b1;
    end
  end

  p_hw_in_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set_in |=> q[INRDY_BIT]);

  p_hw_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set_out && fw_wr && !fw_wdata[ORDY_BIT]) |=> q[ORDY_BIT]);

  p_fw_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_wr && !hw_set_in && !hw_set_out) |=> (q == $past(fw_wdata)));

endmodule

// File: rtl/ep_hs_decide.sv
module ep_hs_decide
  import usb_ep_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
)(
  input  logic             tok_in,
  input  logic             tok_out,
  input  logic             en,
  input  logic             swap,
  input  logic             in_nrdy,
  input  logic             out_rdy,
  input  logic             stall,
  input  logic [CNT_W-1:0] cnt,
  output logic             dec_valid,
  output hs_e              dec_code,
  output logic             dec_bank,
  output logic [CNT_W-1:0] dec_len,
  output logic             arm_in,
  output logic             arm_out
);

  always_comb begin
    dec_valid = 1'b0;
    dec_code  = HS_NONE;
    dec_bank  = 1'b0;
    dec_len   = '0;
    arm_in    = 1'b0;
    arm_out   = 1'b0;
    if (en && tok_in) begin
      dec_valid = 1'b1;
      dec_bank  = pick_bank(swap, 1'b1);
      if (in_nrdy) begin
        dec_code = stall ? HS_STALL : HS_NAK;
      end else begin
        dec_code = HS_DATA;
        dec_len  = clamp_len(cnt, FIFO_DEPTH);
        arm_in   = 1'b1;
      end
    end else if (en && tok_out) begin
      dec_valid = 1'b1;
      dec_bank  = pick_bank(swap, 1'b0);
      if (out_rdy) begin
        dec_code = HS_NAK;
      end else begin
        dec_code = HS_ACK;
        arm_out  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ep_addr_gen.sv
module ep_addr_gen
  import usb_ep_pkg::*;
#(
  parameter int EP_ID      = 3,
  parameter int FIFO_DEPTH = 8,
  parameter int NUM_EP     = 4,
  localparam int IDX_W     = $clog2(FIFO_DEPTH),
  localparam int ADDR_W    = $clog2(NUM_EP * FIFO_DEPTH)
)(
  input  logic [IDX_W-1:0]  byte_idx,
  output logic [ADDR_W-1:0] ram_addr
);

  always_comb begin
    ram_addr = ADDR_W'(win_addr(EP_ID, FIFO_DEPTH, int'(byte_idx)));
  end

  always_comb begin
    p_addr_window_r8: assert (int'(ram_addr) >= EP_ID * FIFO_DEPTH &&
                              int'(ram_addr) <  (EP_ID + 1) * FIFO_DEPTH);
  end

endmodule

// File: rtl/usb_intr_ep_ctrl.sv
module usb_intr_ep_ctrl
  import usb_ep_pkg::*;
#(
  parameter int EP_ID      = 3,
  parameter int FIFO_DEPTH = 8,
  parameter int NUM_EP     = 4,
  localparam int IDX_W     = $clog2(FIFO_DEPTH),
  localparam int ADDR_W    = $clog2(NUM_EP * FIFO_DEPTH)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              stall_req,
  input  logic              tok_in,
  input  logic              tok_out,
  input  logic              xfer_done,
  input  logic              xfer_ok,
  output logic              hs_valid,
  output logic [2:0]        hs_code,
  output logic              hs_bank,
  output logic [CNT_W-1:0]  tx_len,
  input  logic [IDX_W-1:0]  byte_idx,
  output logic [ADDR_W-1:0] ram_addr
);

  logic [REG_W-1:0] ctrl_q;
  logic             ep_en;
  logic             dec_valid, dec_bank, arm_in, arm_out;
  hs_e              dec_code;
  logic [CNT_W-1:0] dec_len;
  logic             pend_in, pend_out;
  logic             hw_set_in, hw_set_out, done_good;

  assign ep_en      = ctrl_q[EN_BIT];
  assign done_good  = xfer_done && xfer_ok && ep_en;
  assign hw_set_in  = done_good && pend_in;
  assign hw_set_out = done_good && pend_out;
  assign cfg_rdata  = ctrl_q;

  ep_ctrl_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .fw_wr     (cfg_wr),
    .fw_wdata  (cfg_wdata),
    .hw_set_in (hw_set_in),
    .hw_set_out(hw_set_out),
    .q         (ctrl_q)
  );

  ep_hs_decide #(.FIFO_DEPTH(FIFO_DEPTH)) u_dec (
    .tok_in   (tok_in),
    .tok_out  (tok_out),
    .en       (ep_en),
    .swap     (ctrl_q[SEL_BIT]),
    .in_nrdy  (ctrl_q[INRDY_BIT]),
    .out_rdy  (ctrl_q[ORDY_BIT]),
    .stall    (stall_req),
    .cnt      (ctrl_q[CNT_W-1:0]),
    .dec_valid(dec_valid),
    .dec_code (dec_code),
    .dec_bank (dec_bank),
    .dec_len  (dec_len),
    .arm_in   (arm_in),
    .arm_out  (arm_out)
  );

  ep_addr_gen #(.EP_ID(EP_ID), .FIFO_DEPTH(FIFO_DEPTH), .NUM_EP(NUM_EP)) u_addr (
    .byte_idx(byte_idx),
    .ram_addr(ram_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_valid <= 1'b0;
      hs_code  <= HS_NONE;
      hs_bank  <= 1'b0;
      tx_len   <= '0;
      pend_in  <= 1'b0;
      pend_out <= 1'b0;
    end else begin
      hs_valid <= dec_valid;
      hs_code  <= dec_code;
      hs_bank  <= dec_bank;
      tx_len   <= dec_len;
      if (dec_valid) begin
        pend_in  <= arm_in;
        pend_out <= arm_out;
      end else if (xfer_done) begin
        pend_in  <= 1'b0;
        pend_out <= 1'b0;
      end
    end
  end

  p_reply_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((tok_in || tok_out) && ep_en) |=> hs_valid);

  p_silent_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ep_en && !xfer_done) |=> ($stable(ctrl_q[ORDY_BIT]) || $past(cfg_wr)));

  p_no_reply_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_en |=> !hs_valid);

  p_stall_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && hs_code == HS_STALL) |-> $past(stall_req));

  p_len_capped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tx_len) <= FIFO_DEPTH);

  p_nak_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_out && !tok_in && ep_en && ctrl_q[ORDY_BIT]) |=> (hs_code == HS_NAK));

  p_one_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_in && pend_out));

endmodule

// File: tb/test_usb_intr_ep_ctrl.sv
module test_usb_intr_ep_ctrl;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       stall_req = 1'b0;
  logic       tok_in = 1'b0, tok_out = 1'b0;
  logic       xfer_done = 1'b0, xfer_ok = 1'b0;
  logic       hs_valid, hs_bank;
  logic [2:0] hs_code;
  logic [3:0] tx_len;
  logic [2:0] byte_idx = '0;
  logic [4:0] ram_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  localparam logic [2:0] C_DATA = 3'd1, C_ACK = 3'd2, C_NAK = 3'd3, C_STALL = 3'd4;

  usb_intr_ep_ctrl i_usb_intr_ep_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .stall_req(stall_req), .tok_in(tok_in),
    .tok_out(tok_out), .xfer_done(xfer_done), .xfer_ok(xfer_ok),
    .hs_valid(hs_valid), .hs_code(hs_code), .hs_bank(hs_bank),
    .tx_len(tx_len), .byte_idx(byte_idx), .ram_addr(ram_addr)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic fw_write(input logic [7:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  // Issue a token; return at the negedge where the reply is visible.
  task automatic token(input bit is_in);
    @(negedge clk);
    if (is_in) tok_in = 1'b1; else tok_out = 1'b1;
    @(negedge clk);
    tok_in = 1'b0; tok_out = 1'b0;
  endtask

  task automatic finish_xfer(input bit ok);
    @(negedge clk); xfer_done = 1'b1; xfer_ok = ok;
    @(negedge clk); xfer_done = 1'b0; xfer_ok = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "ctrl after reset", cfg_rdata, 8'h00);
    chk("R1", "hs_valid after reset", hs_valid, 0);
  endtask

  task automatic t_rw();
    fw_write(8'h5A);
    chk("R2", "readback 0x5A", cfg_rdata, 8'h5A);
    fw_write(8'h00);
    chk("R2", "readback 0x00", cfg_rdata, 8'h00);
  endtask

  task automatic t_disabled();
    fw_write(8'h05);
    token(1);
    chk("R9", "no reply IN disabled", hs_valid, 0);
    token(0);
    chk("R9", "no reply OUT disabled", hs_valid, 0);
    finish_xfer(1);
    chk("R9", "flags unchanged disabled", cfg_rdata, 8'h05);
  endtask

  task automatic t_in_data();
    fw_write(8'h85);
    token(1);
    chk("R3", "IN valid", hs_valid, 1);
    chk("R3", "IN code DATA", hs_code, C_DATA);
    chk("R3", "IN len", tx_len, 5);
    chk("R7", "IN bank swap0", hs_bank, 0);
    @(negedge clk);
    chk("R3", "reply is one pulse", hs_valid, 0);
    finish_xfer(0);
    chk("R5", "failed IN keeps flag", cfg_rdata, 8'h85);
    token(1);
    chk("R3", "IN retry DATA", hs_code, C_DATA);
    finish_xfer(1);
    chk("R5", "acked IN sets bit4", cfg_rdata, 8'h95);
  endtask

  task automatic t_nak_stall();
    token(1);
    chk("R4", "IN not ready NAK", hs_code, C_NAK);
    chk("R4", "NAK len 0", tx_len, 0);
    stall_req = 1'b1;
    token(1);
    chk("R4", "IN stall", hs_code, C_STALL);
    stall_req = 1'b0;
  endtask

  task automatic t_len_cap();
    fw_write(8'h8F);
    token(1);
    chk("R3", "count 15 capped", tx_len, 8);
    fw_write(8'h88);
    token(1);
    chk("R3", "count 8 kept", tx_len, 8);
  endtask

  task automatic t_out();
    fw_write(8'hC0);
    token(0);
    chk("R6", "OUT ACK", hs_code, C_ACK);
    chk("R7", "OUT bank swap1", hs_bank, 0);
    finish_xfer(1);
    chk("R6", "OUT sets bit5", cfg_rdata, 8'hE0);
    token(0);
    chk("R6", "OUT full NAK", hs_code, C_NAK);
    finish_xfer(1);
    chk("R6", "full buffer unchanged", cfg_rdata, 8'hE0);
  endtask

  task automatic t_bank();
    fw_write(8'hC3);
    token(1);
    chk("R7", "IN bank swap1", hs_bank, 1);
    fw_write(8'h80);
    token(0);
    chk("R7", "OUT bank swap0", hs_bank, 1);
  endtask

  task automatic t_hw_wins();
    fw_write(8'h80);
    token(0);
    chk("R10", "OUT ACK before race", hs_code, C_ACK);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 8'h81; xfer_done = 1'b1; xfer_ok = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; xfer_done = 1'b0; xfer_ok = 1'b0;
    chk("R10", "hw set wins", cfg_rdata, 8'hA1);
  endtask

  task automatic t_addr();
    for (int i = 0; i < 8; i++) begin
      byte_idx = 3'(i);
      #1;
      chk("R8", "ram_addr", ram_addr, 24 + i);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rw();
    t_disabled();
    t_in_data();
    t_nak_stall();
    t_len_cap();
    t_out();
    t_bank();
    t_hw_wins();
    t_addr();
    report();
  end

endmodule